// File: doc/BRIEF.md
# Programmable Almost-Full / Almost-Empty Flag Unit

This block keeps the two threshold offsets of a dual-clock FIFO and turns the FIFO's occupancy counts into two early-warning flags. The offset for the almost-empty flag (X) is compared in the read clock domain against the number of stored words. The offset for the almost-full flag (Y) is compared in the write clock domain against the number of free locations. Each flag is active low and passes through two register stages in its own domain.

The way the offsets are set is chosen once, when reset is released, from two select inputs. The block can load one of two fixed preset values into both offsets. It can take Y and then X from the low bits of the port-A write bus. It can also shift the offsets in one bit per write clock, with the high select input acting as an active-low shift enable and the low select input carrying the data. Until the offsets are set, write requests are held back from the FIFO.

Top module: `flag_offset_unit`

## Requirements
- R1: While `rst_n` is low, each `wclk` edge samples {`sel_hi`,`sel_lo`}. The last value sampled before release picks the method: 2'b00 selects preset 64, 2'b01 selects preset 8, 2'b10 selects parallel load and 2'b11 selects serial load. Changes of the selects after release do not change the method.
- R2: In either preset method, both `x_ofs` and `y_ofs` equal the preset (64 or 8) from release onward, and `cfg_ready` is high at once.
- R3: In parallel mode, the first `wclk` edge after release with `wr_en` high loads `y_ofs` from `ofs_wr_data`. The second such edge loads `x_ofs`. Later writes leave both unchanged, and cycles with `wr_en` low load nothing.
- R4: `fifo_wr_go` equals `wr_en` when `cfg_ready` is high and is low otherwise. In parallel mode it stays low during the two loading writes.
- R5: In serial mode, each `wclk` edge with `sel_hi` low shifts `sel_lo` into the chain. After 2*AW bits, the first bit is the MSB of `y_ofs` and the last bit is the LSB of `x_ofs`. Edges with `sel_hi` high shift nothing.
- R6: In serial mode, `serial_done` and `cfg_ready` go high after the 2*AW-th shifted bit. Further serial bits leave both offsets unchanged until the next reset.
- R7: `almost_empty_n` is low when `rd_word_cnt` <= `x_ofs` and high otherwise. The result appears two `rclk` edges after the count is sampled.
- R8: `almost_full_n` is low when `free_cnt` <= `y_ofs` and high otherwise. The result appears two `wclk` edges after the count is sampled.
- R9: While reset is held, `almost_full_n`, `almost_empty_n`, `cfg_ready`, `serial_done` and `fifo_wr_go` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously in both domains |
| sel_hi | input | 1 | Method select high bit; active-low shift enable in serial mode |
| sel_lo | input | 1 | Method select low bit; serial data in serial mode |
| wr_en | input | 1 | Port-A write request |
| ofs_wr_data | input | AW | Low bits of the port-A write bus, used for parallel loading |
| free_cnt | input | AW+1 | Free locations, write domain |
| rd_word_cnt | input | AW+1 | Stored words, read domain |
| almost_full_n | output | 1 | Almost-full flag, active low, write domain |
| almost_empty_n | output | 1 | Almost-empty flag, active low, read domain |
| x_ofs | output | AW | Current almost-empty offset |
| y_ofs | output | AW | Current almost-full offset |
| cfg_ready | output | 1 | Offsets are set |
| serial_done | output | 1 | Serial load complete |
| fifo_wr_go | output | 1 | Write request passed on to the FIFO |

## Verification
The hardest case to reach is a serial load that stops partway, resumes, and then receives extra bits after completion. The bench shifts a random 18-bit pattern in two bursts separated by idle cycles with the enable high. It checks that the block is not yet ready between the bursts. After completion it shifts further bits and checks that both offsets keep their values. The flag comparisons are exercised at the boundaries (count equal to the offset, one above it, zero and full depth) under each method, with random counts mixed in.

// File: rtl/flag_offset_unit.sv
module flag_offset_unit #(
  parameter int AW        = 9,
  parameter int PRESET_LO = 8,
  parameter int PRESET_HI = 64
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          sel_hi,
  input  logic          sel_lo,
  input  logic          wr_en,
  input  logic [AW-1:0] ofs_wr_data,
  input  logic [AW:0]   free_cnt,
  input  logic [AW:0]   rd_word_cnt,
  output logic          almost_full_n,
  output logic          almost_empty_n,
  output logic [AW-1:0] x_ofs,
  output logic [AW-1:0] y_ofs,
  output logic          cfg_ready,
  output logic          serial_done,
  output logic          fifo_wr_go
);
  localparam int SBITS = 2 * AW;
  localparam int SCW   = $clog2(SBITS + 1);
  localparam logic [AW-1:0] P_LO = AW'(PRESET_LO);
  localparam logic [AW-1:0] P_HI = AW'(PRESET_HI);

  typedef enum logic [1:0] {
    M_PRE_HI = 2'b00,
    M_PRE_LO = 2'b01,
    M_PAR    = 2'b10,
    M_SER    = 2'b11
  } mode_t;

  mode_t          mode_q;
  logic [AW-1:0]  x_q, y_q;
  logic [1:0]     par_cnt;
  logic [SCW-1:0] ser_cnt;
  logic           ser_done_q;
  logic           af_s1, af_q, ae_s1, ae_q;
  logic [1:0]     w_age, r_age;

  always_ff @(posedge wclk) begin
    if (!rst_n) begin
      mode_q     <= mode_t'({sel_hi, sel_lo});
      par_cnt    <= '0;
      ser_cnt    <= '0;
      ser_done_q <= 1'b0;
      case ({sel_hi, sel_lo})
        2'b00:   begin x_q <= P_HI; y_q <= P_HI; end
        2'b01:   begin x_q <= P_LO; y_q <= P_LO; end
        default: begin x_q <= '0;   y_q <= '0;   end
      endcase
    end else begin
      if (mode_q == M_PAR && wr_en && par_cnt != 2'd2) begin
        if (par_cnt == 2'd0) y_q <= ofs_wr_data;
        else                 x_q <= ofs_wr_data;
        par_cnt <= par_cnt + 2'd1;
      end
      if (mode_q == M_SER && !sel_hi && !ser_done_q) begin
        {y_q, x_q} <= {y_q[AW-2:0], x_q, sel_lo};
        ser_cnt    <= ser_cnt + 1'b1;
        if (ser_cnt == SCW'(SBITS - 1)) ser_done_q <= 1'b1;
      end
    end
  end

  assign cfg_ready = rst_n && (!mode_q[1] ||
                               (mode_q == M_PAR && par_cnt == 2'd2) ||
                               (mode_q == M_SER && ser_done_q));
  assign fifo_wr_go  = wr_en && cfg_ready;
  assign serial_done = rst_n && ser_done_q;
  assign x_ofs = x_q;
  assign y_ofs = y_q;

  always_ff @(posedge wclk) begin
    if (!rst_n) begin
      af_s1 <= 1'b0;
      af_q  <= 1'b0;
      w_age <= '0;
    end else begin
      af_s1 <= free_cnt > {1'b0, y_q};
      af_q  <= af_s1;
      if (w_age != 2'd3) w_age <= w_age + 2'd1;
    end
  end

  always_ff @(posedge rclk) begin
    if (!rst_n) begin
      ae_s1 <= 1'b0;
      ae_q  <= 1'b0;
      r_age <= '0;
    end else begin
      ae_s1 <= rd_word_cnt > {1'b0, x_q};
      ae_q  <= ae_s1;
      if (r_age != 2'd3) r_age <= r_age + 2'd1;
    end
  end

  assign almost_full_n  = af_q;
  assign almost_empty_n = ae_q;

  AST_MODE_HELD: assert property (@(posedge wclk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_q)); // R1
  AST_PRESET_VAL: assert property (@(posedge wclk) disable iff (!rst_n)
    !mode_q[1] |-> (x_q == y_q) && (x_q == P_LO || x_q == P_HI) && cfg_ready); // R2
  AST_X_AFTER_Y: assert property (@(posedge wclk) disable iff (!rst_n)
    (mode_q == M_PAR && $past(rst_n) && !$stable(x_q)) |-> $past(par_cnt) == 2'd1); // R3
  AST_NO_EARLY_GO: assert property (@(posedge wclk) disable iff (!rst_n)
    (mode_q == M_PAR && par_cnt != 2'd2) |-> !fifo_wr_go); // R4
  AST_DONE_STICKY: assert property (@(posedge wclk) disable iff (!rst_n)
    ser_done_q |=> ser_done_q); // R6
  AST_OFS_FROZEN: assert property (@(posedge wclk) disable iff (!rst_n)
    (cfg_ready && $past(cfg_ready)) |-> $stable({x_q, y_q})); // R6
  AST_AE_TRACK: assert property (@(posedge rclk) disable iff (!rst_n)
    r_age >= 2'd2 |-> almost_empty_n == ($past(rd_word_cnt, 2) > {1'b0, $past(x_q, 2)})); // R7
  AST_AF_TRACK: assert property (@(posedge wclk) disable iff (!rst_n)
    w_age >= 2'd2 |-> almost_full_n == ($past(free_cnt, 2) > {1'b0, $past(y_q, 2)})); // R8
endmodule

// File: tb/flag_offset_unit_tb_top.sv
module flag_offset_unit_tb_top;
  localparam int AW = 9;
  localparam int NB = 2 * AW;

  logic wclk = 1'b0, rclk = 1'b0;
  always #5 wclk = ~wclk;
  always #7 rclk = ~rclk;

  logic rst_n = 1'b0, sel_hi = 1'b0, sel_lo = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] ofs_wr_data = '0;
  logic [AW:0] free_cnt = '0, rd_word_cnt = '0;
  logic almost_full_n, almost_empty_n, cfg_ready, serial_done, fifo_wr_go;
  logic [AW-1:0] x_ofs, y_ofs;

  flag_offset_unit #(.AW(AW)) dut_i (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .sel_hi(sel_hi), .sel_lo(sel_lo),
    .wr_en(wr_en), .ofs_wr_data(ofs_wr_data), .free_cnt(free_cnt),
    .rd_word_cnt(rd_word_cnt), .almost_full_n(almost_full_n),
    .almost_empty_n(almost_empty_n), .x_ofs(x_ofs), .y_ofs(y_ofs),
    .cfg_ready(cfg_ready), .serial_done(serial_done), .fifo_wr_go(fifo_wr_go));

  int checks = 0, fails = 0;
  int x_exp = 0, y_exp = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int flag_exp(int cnt, int ofs);
    return (cnt > ofs) ? 1 : 0;
  endfunction

  task automatic reset_mode(logic [1:0] m);
    @(negedge wclk);
    rst_n = 1'b0; sel_hi = m[1]; sel_lo = m[0]; wr_en = 1'b0;
    repeat (6) @(negedge wclk);
    chk(almost_full_n == 0, "R9 af_n in reset", almost_full_n, 0);
    chk(almost_empty_n == 0, "R9 ae_n in reset", almost_empty_n, 0);
    chk({cfg_ready, serial_done} == 0, "R9 ready/done in reset", {cfg_ready, serial_done}, 0);
    wr_en = 1'b1;
    #1 chk(fifo_wr_go == 0, "R9 go in reset", fifo_wr_go, 0);
    wr_en = 1'b0;
    rst_n = 1'b1; sel_hi = 1'b1; sel_lo = 1'b0;
  endtask

  task automatic ae_chk(int cnt, string tag);
    @(negedge rclk) rd_word_cnt = cnt[AW:0];
    repeat (2) @(posedge rclk);
    @(negedge rclk);
    chk(almost_empty_n == flag_exp(cnt, x_exp), tag, almost_empty_n, flag_exp(cnt, x_exp));
  endtask

  task automatic af_chk(int cnt, string tag);
    @(negedge wclk) free_cnt = cnt[AW:0];
    repeat (2) @(posedge wclk);
    @(negedge wclk);
    chk(almost_full_n == flag_exp(cnt, y_exp), tag, almost_full_n, flag_exp(cnt, y_exp));
  endtask

  task automatic flag_sweep(int nrand);
    ae_chk(x_exp, "R7 ae at count==X");
    ae_chk(x_exp + 1, "R7 ae at count==X+1");
    ae_chk(0, "R7 ae at zero");
    ae_chk(1 << AW, "R7 ae at full depth");
    af_chk(y_exp, "R8 af at free==Y");
    af_chk(y_exp + 1, "R8 af at free==Y+1");
    af_chk(0, "R8 af at zero");
    af_chk(1 << AW, "R8 af at full depth");
    for (int i = 0; i < nrand; i++) begin
      ae_chk(int'($urandom_range(0, 1 << AW)), "R7 ae random");
      af_chk(int'($urandom_range(0, 1 << AW)), "R8 af random");
    end
  endtask

  task automatic shift_bits(logic [NB-1:0] v, int from, int cnt);
    for (int i = from; i < from + cnt; i++) begin
      @(negedge wclk);
      sel_hi = 1'b0; sel_lo = v[NB-1-i];
    end
    @(negedge wclk);
    sel_hi = 1'b1;
  endtask

  initial begin
    int unsigned seed;
    logic [NB-1:0] pat;
    logic [AW-1:0] d0, d1;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge wclk);

    // preset 64
    reset_mode(2'b00);
    @(negedge wclk);
    x_exp = 64; y_exp = 64;
    chk(x_ofs == 64 && y_ofs == 64, "R2 preset 64", x_ofs, 64);
    chk(cfg_ready == 1, "R2 ready in preset", cfg_ready, 1);
    for (int i = 0; i < 6; i++) begin
      @(negedge wclk);
      sel_hi = i[0]; sel_lo = i[1]; wr_en = 1'b1; ofs_wr_data = AW'($urandom);
    end
    @(negedge wclk);
    chk(x_ofs == 64 && y_ofs == 64, "R1 selects ignored after release", x_ofs, 64);
    chk(fifo_wr_go == 1, "R4 go when ready", fifo_wr_go, 1);
    wr_en = 1'b0; sel_hi = 1'b1;
    #1 chk(fifo_wr_go == 0, "R4 no go without wr_en", fifo_wr_go, 0);
    flag_sweep(10);

    // preset 8
    reset_mode(2'b01);
    @(negedge wclk);
    x_exp = 8; y_exp = 8;
    chk(x_ofs == 8 && y_ofs == 8, "R2 preset 8", y_ofs, 8);
    flag_sweep(10);

    // parallel
    reset_mode(2'b10);
    d0 = AW'($urandom); d1 = AW'($urandom);
    @(negedge wclk);
    chk(cfg_ready == 0, "R3 not ready before loads", cfg_ready, 0);
    repeat (3) @(negedge wclk);
    chk(y_ofs == 0 && x_ofs == 0, "R3 idle cycles load nothing", y_ofs, 0);
    wr_en = 1'b1; ofs_wr_data = d0;
    #1 chk(fifo_wr_go == 0, "R4 first load write blocked", fifo_wr_go, 0);
    @(negedge wclk);
    chk(y_ofs == d0, "R3 Y from first write", y_ofs, d0);
    wr_en = 1'b0;
    @(negedge wclk);
    wr_en = 1'b1; ofs_wr_data = d1;
    #1 chk(fifo_wr_go == 0, "R4 second load write blocked", fifo_wr_go, 0);
    @(negedge wclk);
    chk(x_ofs == d1, "R3 X from second write", x_ofs, d1);
    chk(cfg_ready == 1, "R3 ready after two writes", cfg_ready, 1);
    ofs_wr_data = ~d1;
    #1 chk(fifo_wr_go == 1, "R4 go after loads", fifo_wr_go, 1);
    @(negedge wclk);
    wr_en = 1'b0;
    chk(x_ofs == d1 && y_ofs == d0, "R3 later writes ignored", x_ofs, d1);
    x_exp = d1; y_exp = d0;
    flag_sweep(10);

    // serial
    reset_mode(2'b11);
    pat = NB'({$urandom, $urandom});
    shift_bits(pat, 0, 5);
    repeat (3) @(negedge wclk);
    chk(cfg_ready == 0 && serial_done == 0, "R6 not done after partial", serial_done, 0);
    wr_en = 1'b1;
    #1 chk(fifo_wr_go == 0, "R4 go blocked in serial load", fifo_wr_go, 0);
    wr_en = 1'b0;
    chk(x_ofs[4:0] == pat[NB-1 -: 5], "R5 partial shift held with enable high", x_ofs[4:0], pat[NB-1 -: 5]);
    shift_bits(pat, 5, NB - 5);
    chk(y_ofs == pat[NB-1:AW], "R5 Y gets first bits", y_ofs, pat[NB-1:AW]);
    chk(x_ofs == pat[AW-1:0], "R5 X gets last bits", x_ofs, pat[AW-1:0]);
    chk(serial_done == 1 && cfg_ready == 1, "R6 done after all bits", serial_done, 1);
    shift_bits(~pat, 0, 6);
    chk(x_ofs == pat[AW-1:0] && y_ofs == pat[NB-1:AW], "R6 extra bits ignored", x_ofs, pat[AW-1:0]);
    x_exp = pat[AW-1:0]; y_exp = pat[NB-1:AW];
    flag_sweep(10);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge wclk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule